// File: doc/BRIEF.md
# Serial Group-Addressed Register Loader

This block is the host-facing control port of a dual-channel frequency synthesizer. A host drives three slow pins: a serial clock, a serial data line and a load enable. Bits enter a shift register one per rising serial-clock edge, most significant bit first. When the enable goes high, the word in the shift register is copied into one of four destination latches. The last two bits shifted in (the group code) choose the latch. The latches hold the channel-1 divide ratio, the channel-2 divide ratio, the reference divide ratio and a control word. The control word is decoded into individual parallel outputs.

All three host pins are sampled by two-flop synchronisers in the system clock domain, and edges are detected after synchronisation. The serial interface is a plain pin protocol with no valid/ready handshake. The host paces it, and no back-pressure path exists. The block also enforces a start-up rule: the reference and control latches must be written before either divider latch. Two sticky flags show that the reference and control latches have been written. A sticky error flag records any divider write that came too early.

Top module: `serial_group_loader`

## Requirements
- R1: After reset every latch output, every decoded control output and all three flags are 0.
- R2: Each synchronised rising edge of `sclk_i` shifts `sdata_i` into the shift register. The first bit sent ends up most significant, and the final bit sent is bit 0.
- R3: The group code is {bit 1, bit 0} of the shift register. 2'b00 selects the control latch, 2'b01 channel 1, 2'b10 channel 2 and 2'b11 the reference latch. Only the selected latch changes on a load.
- R4: A load happens once per synchronised rising edge of `sen_i`. Outputs take the new value on the second system clock edge after the edge where `sen_i` is first sampled high.
- R5: The payload is the shift register above the group code. A channel latch takes payload bits [N_W-1:0] (17 by default) and the reference latch takes payload bits [R_W-1:0] (12 by default). Bits sent before the payload are ignored.
- R6: The control payload bits are: [10] test mode, [9] pump polarity invert, [8:7] channel-1 pump current code, [6:5] channel-2 pump current code, [4:3] lock-detect output mode, [2] channel-1 standby, [1] channel-2 standby, [0] reference standby. Pump codes 00/01/10/11 (1x/2x/4x/8x) appear unchanged on the outputs.
- R7: Rising edges of `sclk_i` seen while the synchronised `sen_i` is high do not shift the register.
- R8: `ref_loaded_o` and `ctrl_loaded_o` go to 1 on the first reference or control load and stay 1 until reset.
- R9: `order_err_o` goes to 1 when a channel latch is loaded while either loaded flag is still 0. It stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Host serial clock (asynchronous) |
| sdata_i | input | 1 | Host serial data (asynchronous) |
| sen_i | input | 1 | Host load enable (asynchronous) |
| ch1_div_o | output | N_W | Channel-1 divide ratio |
| ch2_div_o | output | N_W | Channel-2 divide ratio |
| ref_div_o | output | R_W | Reference divide ratio |
| test_mode_o | output | 1 | Test mode select |
| pump_inv_o | output | 1 | Charge-pump polarity invert |
| ch1_pump_o | output | 2 | Channel-1 pump current code |
| ch2_pump_o | output | 2 | Channel-2 pump current code |
| lock_mode_o | output | 2 | Lock-detect output mode |
| sby_ch1_o | output | 1 | Channel-1 standby |
| sby_ch2_o | output | 1 | Channel-2 standby |
| sby_ref_o | output | 1 | Reference divider standby |
| ref_loaded_o | output | 1 | Reference latch written since reset |
| ctrl_loaded_o | output | 1 | Control latch written since reset |
| order_err_o | output | 1 | A divider was written before reference and control |

## Verification
The assertions assume that each host pin holds its level for at least three system clocks between changes. With that spacing, one pin change becomes exactly one detected edge, two cycles later, and a latch output can move only when `sen_i` was high two cycles earlier. They also assume that `sdata_i` is settled before `sclk_i` rises and that `sen_i` stays low while bits are shifted. The stimulus meets these assumptions by placing every pin change on a falling system edge and spacing changes three to four cycles apart. The one deliberate exception is the R7 case, where serial clocks are sent with the enable held high.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

  typedef enum logic [1:0] {
    GRP_CTRL = 2'b00,
    GRP_CH1  = 2'b01,
    GRP_CH2  = 2'b10,
    GRP_REF  = 2'b11
  } grp_e;

  // control payload layout, most significant field first
  typedef struct packed {
    logic       test_mode;
    logic       pump_inv;
    logic [1:0] ch1_pump;
    logic [1:0] ch2_pump;
    logic [1:0] lock_mode;
    logic       sby_ch1;
    logic       sby_ch2;
    logic       sby_ref;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int GC_W   = 2;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sgl_sync.sv
module sgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], d_i};
  end

  assign lvl_o  = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/sgl_shifter.sv
module sgl_shifter #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/sgl_latches.sv
module sgl_latches
  import sgl_pkg::*;
#(
  parameter int N_W  = 17,
  parameter int R_W  = 12,
  parameter int SR_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [SR_W-1:0] word_i,
  output logic [N_W-1:0]  ch1_o,
  output logic [N_W-1:0]  ch2_o,
  output logic [R_W-1:0]  ref_o,
  output ctrl_t           ctrl_o,
  output logic            wr_ctrl_o,
  output logic            wr_ch1_o,
  output logic            wr_ch2_o,
  output logic            wr_ref_o
);
  localparam int PAY_W = SR_W - GC_W;

  grp_e             grp;
  logic [PAY_W-1:0] payload;

  assign grp     = grp_e'(word_i[GC_W-1:0]);
  assign payload = word_i[SR_W-1:GC_W];

  always_comb begin
    wr_ctrl_o = 1'b0;
    wr_ch1_o  = 1'b0;
    wr_ch2_o  = 1'b0;
    wr_ref_o  = 1'b0;
    if (load_i) begin
      unique case (grp)
        GRP_CTRL: wr_ctrl_o = 1'b1;
        GRP_CH1:  wr_ch1_o  = 1'b1;
        GRP_CH2:  wr_ch2_o  = 1'b1;
        GRP_REF:  wr_ref_o  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch1_o  <= '0;
      ch2_o  <= '0;
      ref_o  <= '0;
      ctrl_o <= '0;
    end else begin
      if (wr_ch1_o)  ch1_o  <= payload[N_W-1:0];
      if (wr_ch2_o)  ch2_o  <= payload[N_W-1:0];
      if (wr_ref_o)  ref_o  <= payload[R_W-1:0];
      if (wr_ctrl_o) ctrl_o <= ctrl_t'(payload[CTRL_W-1:0]);
    end
  end
endmodule

// File: rtl/sgl_order.sv
module sgl_order (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl_i,
  input  logic wr_ch1_i,
  input  logic wr_ch2_i,
  input  logic wr_ref_i,
  output logic ref_loaded_o,
  output logic ctrl_loaded_o,
  output logic order_err_o
);
  logic early_div;
  assign early_div = (wr_ch1_i | wr_ch2_i) & ~(ref_loaded_o & ctrl_loaded_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_loaded_o  <= 1'b0;
      ctrl_loaded_o <= 1'b0;
      order_err_o   <= 1'b0;
    end else begin
      if (wr_ref_i)  ref_loaded_o  <= 1'b1;
      if (wr_ctrl_i) ctrl_loaded_o <= 1'b1;
      if (early_div) order_err_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_group_loader.sv
module serial_group_loader
  import sgl_pkg::*;
#(
  parameter int N_W         = 17,
  parameter int R_W         = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk_i,
  input  logic           sdata_i,
  input  logic           sen_i,
  output logic [N_W-1:0] ch1_div_o,
  output logic [N_W-1:0] ch2_div_o,
  output logic [R_W-1:0] ref_div_o,
  output logic           test_mode_o,
  output logic           pump_inv_o,
  output logic [1:0]     ch1_pump_o,
  output logic [1:0]     ch2_pump_o,
  output logic [1:0]     lock_mode_o,
  output logic           sby_ch1_o,
  output logic           sby_ch2_o,
  output logic           sby_ref_o,
  output logic           ref_loaded_o,
  output logic           ctrl_loaded_o,
  output logic           order_err_o
);
  localparam int PAY_W = max3(N_W, R_W, CTRL_W);
  localparam int SR_W  = PAY_W + GC_W;
  localparam int NPIN  = 3;
  localparam int P_CK  = 0;
  localparam int P_DAT = 1;
  localparam int P_EN  = 2;

  logic [NPIN-1:0] pin_raw, pin_lvl, pin_rise;
  assign pin_raw = {sen_i, sdata_i, sclk_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    sgl_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_raw[g]),
      .lvl_o (pin_lvl[g]),
      .rise_o(pin_rise[g])
    );
  end

  logic            shift_en, load_en;
  logic [SR_W-1:0] word;

  assign shift_en = pin_rise[P_CK] & ~pin_lvl[P_EN];
  assign load_en  = pin_rise[P_EN];

  sgl_shifter #(.W(SR_W)) i_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift_i(shift_en),
    .bit_i  (pin_lvl[P_DAT]),
    .word_o (word)
  );

  ctrl_t ctrl;
  logic  wr_ctrl, wr_ch1, wr_ch2, wr_ref;

  sgl_latches #(.N_W(N_W), .R_W(R_W), .SR_W(SR_W)) i_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_en),
    .word_i   (word),
    .ch1_o    (ch1_div_o),
    .ch2_o    (ch2_div_o),
    .ref_o    (ref_div_o),
    .ctrl_o   (ctrl),
    .wr_ctrl_o(wr_ctrl),
    .wr_ch1_o (wr_ch1),
    .wr_ch2_o (wr_ch2),
    .wr_ref_o (wr_ref)
  );

  sgl_order i_order (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl_i    (wr_ctrl),
    .wr_ch1_i     (wr_ch1),
    .wr_ch2_i     (wr_ch2),
    .wr_ref_i     (wr_ref),
    .ref_loaded_o (ref_loaded_o),
    .ctrl_loaded_o(ctrl_loaded_o),
    .order_err_o  (order_err_o)
  );

  assign test_mode_o = ctrl.test_mode;
  assign pump_inv_o  = ctrl.pump_inv;
  assign ch1_pump_o  = ctrl.ch1_pump;
  assign ch2_pump_o  = ctrl.ch2_pump;
  assign lock_mode_o = ctrl.lock_mode;
  assign sby_ch1_o   = ctrl.sby_ch1;
  assign sby_ch2_o   = ctrl.sby_ch2;
  assign sby_ref_o   = ctrl.sby_ref;
endmodule

// File: rtl/sgl_checker.sv
module sgl_checker #(
  parameter int N_W = 17,
  parameter int R_W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sen_i,
  input logic [N_W-1:0] ch1_div_o,
  input logic [N_W-1:0] ch2_div_o,
  input logic [R_W-1:0] ref_div_o,
  input logic           ref_loaded_o,
  input logic           ctrl_loaded_o,
  input logic           order_err_o
);
  logic [N_W-1:0] ch1_q, ch2_q;
  logic [R_W-1:0] ref_q;
  logic           ch1_mv, ch2_mv, ref_mv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch1_q <= '0;
      ch2_q <= '0;
      ref_q <= '0;
    end else begin
      ch1_q <= ch1_div_o;
      ch2_q <= ch2_div_o;
      ref_q <= ref_div_o;
    end
  end

  assign ch1_mv = ch1_div_o != ch1_q;
  assign ch2_mv = ch2_div_o != ch2_q;
  assign ref_mv = ref_div_o != ref_q;

  AST_REF_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_loaded_o |=> ref_loaded_o); // R8
  AST_CTRL_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_loaded_o |=> ctrl_loaded_o); // R8
  AST_ORDER_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    order_err_o |=> order_err_o); // R9
  AST_ORDER_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(order_err_o) |-> !($past(ref_loaded_o) && $past(ctrl_loaded_o))); // R9
  AST_ONE_DESTINATION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ch1_mv, ch2_mv, ref_mv}) <= 1); // R3
  AST_LOAD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1_mv || ch2_mv || ref_mv) |-> $past(sen_i, 2)); // R4
endmodule

bind serial_group_loader sgl_checker #(.N_W(N_W), .R_W(R_W)) i_sgl_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .sen_i        (sen_i),
  .ch1_div_o    (ch1_div_o),
  .ch2_div_o    (ch2_div_o),
  .ref_div_o    (ref_div_o),
  .ref_loaded_o (ref_loaded_o),
  .ctrl_loaded_o(ctrl_loaded_o),
  .order_err_o  (order_err_o)
);

// File: tb/test_serial_group_loader.sv
`timescale 1ns/1ps
module test_serial_group_loader;
  localparam int N_W = 17;
  localparam int R_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b0, sdata_i = 1'b0, sen_i = 1'b0;
  logic [N_W-1:0] ch1_div_o, ch2_div_o;
  logic [R_W-1:0] ref_div_o;
  logic test_mode_o, pump_inv_o, sby_ch1_o, sby_ch2_o, sby_ref_o;
  logic [1:0] ch1_pump_o, ch2_pump_o, lock_mode_o;
  logic ref_loaded_o, ctrl_loaded_o, order_err_o;

  int tests_run = 0;
  int tests_failed = 0;

  always #5 clk = ~clk;

  serial_group_loader #(.N_W(N_W), .R_W(R_W)) i_serial_group_loader (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i), .sen_i(sen_i),
    .ch1_div_o(ch1_div_o), .ch2_div_o(ch2_div_o), .ref_div_o(ref_div_o),
    .test_mode_o(test_mode_o), .pump_inv_o(pump_inv_o),
    .ch1_pump_o(ch1_pump_o), .ch2_pump_o(ch2_pump_o), .lock_mode_o(lock_mode_o),
    .sby_ch1_o(sby_ch1_o), .sby_ch2_o(sby_ch2_o), .sby_ref_o(sby_ref_o),
    .ref_loaded_o(ref_loaded_o), .ctrl_loaded_o(ctrl_loaded_o),
    .order_err_o(order_err_o)
  );

  // ---------------- behavioural reference model ----------------
  logic [3:0]  h_ck, h_dat, h_en;   // [0] newest sample
  logic [63:0] m_word;
  int          m_ch1, m_ch2, m_ref, m_ctrl;
  bit          m_rl, m_cl, m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      h_ck = 0; h_dat = 0; h_en = 0; m_word = 0;
      m_ch1 = 0; m_ch2 = 0; m_ref = 0; m_ctrl = 0;
      m_rl = 0; m_cl = 0; m_err = 0;
    end else begin
      h_ck  = {h_ck[2:0], sclk_i};
      h_dat = {h_dat[2:0], sdata_i};
      h_en  = {h_en[2:0], sen_i};
      // a pin change is acted on two edges after it is first sampled
      if (h_en[2] && !h_en[3]) begin
        int code;
        longint pay;
        code = int'(m_word[1:0]);
        pay  = longint'(m_word >> 2);
        case (code)
          0: begin m_ctrl = int'(pay % 2048); m_cl = 1; end
          1: begin m_ch1 = int'(pay % (1 << N_W)); if (!(m_rl && m_cl)) m_err = 1; end
          2: begin m_ch2 = int'(pay % (1 << N_W)); if (!(m_rl && m_cl)) m_err = 1; end
          default: begin m_ref = int'(pay % (1 << R_W)); m_rl = 1; end
        endcase
      end else if (h_ck[2] && !h_ck[3] && !h_en[2]) begin
        m_word = (m_word << 1) | 64'(h_dat[2]);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int ctrl_bus();
    return {21'd0, test_mode_o, pump_inv_o, ch1_pump_o, ch2_pump_o, lock_mode_o,
            sby_ch1_o, sby_ch2_o, sby_ref_o};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R3/R5 model ch1", int'(ch1_div_o), m_ch1);
      chk("R2/R3/R5 model ch2", int'(ch2_div_o), m_ch2);
      chk("R2/R3/R5 model ref", int'(ref_div_o), m_ref);
      chk("R6 model ctrl", ctrl_bus(), m_ctrl);
      chk("R8 model flags", {30'd0, ref_loaded_o, ctrl_loaded_o}, {30'd0, m_rl, m_cl});
      chk("R9 model order", int'(order_err_o), int'(m_err));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sclk_i = 0; sdata_i = 0; sen_i = 0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(3);
  endtask

  task automatic shift_bits(input int nbits, input logic [63:0] val);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata_i = val[i];
      wait_n(3);
      sclk_i = 1'b1;
      wait_n(4);
      sclk_i = 1'b0;
      wait_n(3);
    end
  endtask

  task automatic pulse_en();
    sen_i = 1'b1;
    wait_n(4);
    sen_i = 1'b0;
    wait_n(4);
  endtask

  task automatic send(input int nbits, input logic [63:0] val);
    shift_bits(nbits, val);
    pulse_en();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk("R1 ch1", int'(ch1_div_o), 0);
    chk("R1 ref", int'(ref_div_o), 0);
    chk("R1 ctrl", ctrl_bus(), 0);
    chk("R1 flags", {29'd0, ref_loaded_o, ctrl_loaded_o, order_err_o}, 0);

    // R9: divider written first
    send(19, {17'h15A5A, 2'b01});
    chk("R2 ch1 first", int'(ch1_div_o), 'h15A5A);
    chk("R9 early write", int'(order_err_o), 1);
    chk("R8 ref flag still clear", int'(ref_loaded_o), 0);

    do_reset();
    chk("R1 after second reset", int'(order_err_o), 0);

    // R6 control word: test=1 inv=0 ch1=11 ch2=01 lock=10 sby=1,0,1
    send(13, {11'b1_0_11_01_10_1_0_1, 2'b00});
    chk("R6 test_mode", int'(test_mode_o), 1);
    chk("R6 pump_inv", int'(pump_inv_o), 0);
    chk("R6 ch1_pump", int'(ch1_pump_o), 3);
    chk("R6 ch2_pump", int'(ch2_pump_o), 1);
    chk("R6 lock_mode", int'(lock_mode_o), 2);
    chk("R6 standby", {29'd0, sby_ch1_o, sby_ch2_o, sby_ref_o}, 3'b101);
    chk("R8 ctrl flag", int'(ctrl_loaded_o), 1);
    chk("R3 ch1 untouched by ctrl", int'(ch1_div_o), 0);

    send(14, {12'hA5C, 2'b11});
    chk("R5 ref value", int'(ref_div_o), 'hA5C);
    chk("R8 ref flag", int'(ref_loaded_o), 1);

    send(19, {17'h01234, 2'b01});
    send(19, {17'h1FFFF, 2'b10});
    chk("R3 ch1 value", int'(ch1_div_o), 'h01234);
    chk("R3 ch2 value", int'(ch2_div_o), 'h1FFFF);
    chk("R9 legal order", int'(order_err_o), 0);

    // R5: extra leading bits dropped
    send(25, {6'b111111, 17'h00003, 2'b10});
    chk("R5 long ch2", int'(ch2_div_o), 3);
    send(19, {5'b11111, 12'h001, 2'b11});
    chk("R5 long ref", int'(ref_div_o), 1);
    chk("R3 ch1 kept", int'(ch1_div_o), 'h01234);

    // R7: serial clocks while enable high are ignored
    send(19, {17'h00055, 2'b01});
    sen_i = 1'b1;
    wait_n(4);
    shift_bits(4, 64'hF);
    sen_i = 1'b0;
    wait_n(4);
    pulse_en();
    chk("R7 ch1 relatched", int'(ch1_div_o), 'h55);
    chk("R7 ref unchanged", int'(ref_div_o), 1);
    chk("R7 ch2 unchanged", int'(ch2_div_o), 3);

    // R4: exact load latency
    shift_bits(19, {17'h00777, 2'b01});
    sen_i = 1'b1;               // sampled at the next rising edge
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R4 not yet loaded", int'(ch1_div_o), 'h55);
    @(negedge clk);
    chk("R4 loaded on second edge", int'(ch1_div_o), 'h777);
    wait_n(3);
    sen_i = 1'b0;
    wait_n(4);
    chk("R9 still clear", int'(order_err_o), 0);

    wait_n(5);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule